// File: doc/BRIEF.md
# Bit-Masked PHY Control Register Bank

This block is a small set of 32-bit control registers on a single-cycle memory-mapped bus. The upper half of each write word is a per-bit enable for the lower half. Software can therefore change one field without first reading the register back. Each register stores sixteen bits.

Three of the stored fields leave the block as level signals for a downstream PHY controller:

- a per-port reset bit;
- a bit that hands PHY control over to software;
- a six-bit suspend code.

Reads return the stored sixteen bits with zeros above them. Address decode, reset values and readback are all in the bank. Bus protocol beyond one strobe cycle is not.

Top module: `phy_ctl_regbank`

## Requirements
- R1: After reset, `port_rst` is 0, `sw_ovr` is 0, `susp` is 6'h01 and `rdata` is 0. Reads of offsets 0x00 and 0x08 return 0, and a read of offset 0x0C returns 32'h0000_0001.
- R2: When a write hits a mapped register, stored bit n (n from 0 to 15) takes `wdata[n]` only if `wdata[n+16]` is 1. Every stored bit whose enable is 0 keeps its value.
- R3: Bit 12 of the register at offset 0x00 drives `port_rst`, where 1 holds the port in reset and 0 releases it.
- R4: Bit 2 of the register at offset 0x08 drives `sw_ovr`, where 1 selects software control and 0 deselects it.
- R5: Bits 5:0 of the register at offset 0x0C drive `susp`. The code 6'h2A means suspended and 6'h01 means normal operation. Writing 32'h003F_002A gives `susp` = 6'h2A.
- R6: A read of a mapped offset returns `{16'h0000, stored[15:0]}` on `rdata` one cycle after `rd_en`. `rdata[31:16]` is always zero.
- R7: A read of any unmapped offset returns 0 on `rdata`.
- R8: A write to an unmapped offset changes no stored bit and no output, and raises no error.
- R9: A write takes effect at the clock edge that samples `wr_en`. Before that edge the outputs still show the old value, and after it they show the new value.
- R10: When a read and a write hit the same offset in the same cycle, `rdata` returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 32 | Byte offset of the access |
| wdata | input | 32 | Bits 31:16 are the bit enables, bits 15:0 are the data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en`, held until the next read |
| port_rst | output | 1 | Per-port reset level to the PHY controller |
| sw_ovr | output | 1 | Software-control select level |
| susp | output | 6 | Suspend code |

## Verification
The control outputs settle on the clock edge that samples `wr_en`, and `rdata` settles on the edge that samples `rd_en`, so each result is due one edge after its stimulus. The bench drives every strobe on a falling edge and samples on the next falling edge. Each result is therefore read half a period after the edge that produced it, never at an edge. The write-timing check also reads the outputs before the capturing edge, to show that they have not yet moved. The same-cycle read and write check relies on `rdata` being captured at the same edge as the update, so it expects the old value.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int NREG   = 3;

  // register slots
  localparam int SLOT_RST = 0;
  localparam int SLOT_SWC = 1;
  localparam int SLOT_SUS = 2;

  // field placement
  localparam int RST_BIT = 12;
  localparam int SWC_BIT = 2;
  localparam int SUS_LSB = 0;
  localparam int SUS_W   = 6;

  localparam logic [SUS_W-1:0] SUS_RUN  = 6'h01;
  localparam logic [SUS_W-1:0] SUS_STOP = 6'h2A;

  function automatic logic [DATA_W-1:0] slot_offset(input int slot);
    case (slot)
      SLOT_RST: slot_offset = 32'h0000_0000;
      SLOT_SWC: slot_offset = 32'h0000_0008;
      default:  slot_offset = 32'h0000_000C;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] slot_reset(input int slot);
    logic [HALF_W-1:0] v;
    v = '0;
    if (slot == SLOT_SUS) v[SUS_LSB +: SUS_W] = SUS_RUN;
    slot_reset = v;
  endfunction

  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_v,
    input logic [HALF_W-1:0] new_v,
    input logic [HALF_W-1:0] en
  );
    masked_merge = (old_v & ~en) | (new_v & en);
  endfunction
endpackage

// File: rtl/phy_ctl_decode.sv
module phy_ctl_decode
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W = DATA_W,
  parameter int N      = NREG
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      sel,
  output logic              hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    localparam logic [DATA_W-1:0] OFS = slot_offset(i);
    assign sel[i] = (addr == OFS[ADDR_W-1:0]);
  end

  assign hit = |sel;

  always_comb begin
    assert_sel_onehot_R8: assert ($onehot0(sel));
  end
endmodule

// File: rtl/phy_ctl_hreg.sv
module phy_ctl_hreg
  import phy_ctl_pkg::*;
#(
  parameter int               W     = HALF_W,
  parameter logic [W-1:0]     RESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic [W-1:0] en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET;
    else if (we) q <= masked_merge(q, d, en);
  end

  assert_unenabled_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(q)) & ~$past(en)) == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              port_rst,
  output logic              sw_ovr,
  output logic [SUS_W-1:0]  susp
);
  logic [NREG-1:0]   sel;
  logic              hit;
  logic [HALF_W-1:0] store [NREG];
  logic [HALF_W-1:0] rd_mux;
  logic              rd_miss;

  phy_ctl_decode #(.ADDR_W(DATA_W), .N(NREG)) u_dec (
    .addr (addr),
    .sel  (sel),
    .hit  (hit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    phy_ctl_hreg #(.W(HALF_W), .RESET(slot_reset(i))) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en & sel[i]),
      .d     (wdata[HALF_W-1:0]),
      .en    (wdata[DATA_W-1:HALF_W]),
      .q     (store[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rd_mux = store[i];
  end

  assign rd_miss = rd_en & ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{(DATA_W-HALF_W){1'b0}}, rd_mux};
  end

  assign port_rst = store[SLOT_RST][RST_BIT];
  assign sw_ovr   = store[SLOT_SWC][SWC_BIT];
  assign susp     = store[SLOT_SUS][SUS_LSB +: SUS_W];

  assert_rdata_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:HALF_W] == '0);

  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> rdata == '0);

  assert_unmapped_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable({port_rst, sw_ovr, susp}));

  assert_rdata_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/phy_ctl_regbank_tb.sv
`timescale 1ns/1ps
module phy_ctl_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        port_rst, sw_ovr;
  logic [5:0]  susp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] mdl [3];

  always #2.5 clk = ~clk;

  phy_ctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .port_rst(port_rst), .sw_ovr(sw_ovr), .susp(susp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int slot_of(input logic [31:0] a);
    if (a == 32'h0) return 0;
    if (a == 32'h8) return 1;
    if (a == 32'hC) return 2;
    return -1;
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [31:0] d);
    int s = slot_of(a);
    if (s >= 0)
      for (int n = 0; n < 16; n++)
        if (d[n+16]) mdl[s][n] = d[n];
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " port_rst"}, {31'b0, port_rst}, {31'b0, mdl[0][12]});
    check({tag, " sw_ovr"},   {31'b0, sw_ovr},   {31'b0, mdl[1][2]});
    check({tag, " susp"},     {26'b0, susp},     {26'b0, mdl[2][5:0]});
  endtask

  task automatic check_readback(input string tag);
    logic [31:0] v;
    do_read(32'h0, v); check({tag, " rd 0x00"}, v, {16'h0, mdl[0]});
    do_read(32'h8, v); check({tag, " rd 0x08"}, v, {16'h0, mdl[1]});
    do_read(32'hC, v); check({tag, " rd 0x0C"}, v, {16'h0, mdl[2]});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 port_rst", {31'b0, port_rst}, 32'h0);
    check("R1 sw_ovr",   {31'b0, sw_ovr},   32'h0);
    check("R1 susp",     {26'b0, susp},     32'h1);
    check("R1 rdata",    rdata,             32'h0);
    check_readback("R1");
  endtask

  task automatic t_port_reset;
    logic [31:0] v;
    @(negedge clk);
    addr = 32'h0; wdata = 32'h1000_1000; wr_en = 1'b1;
    #1;
    check("R9 before edge", {31'b0, port_rst}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(32'h0, 32'h1000_1000);
    check("R9 after edge", {31'b0, port_rst}, 32'h1);
    check("R3 assert", {31'b0, port_rst}, 32'h1);
    do_read(32'h0, v);
    check("R6 readback", v, 32'h0000_1000);
    do_write(32'h0, 32'h1000_0000);
    check("R3 release", {31'b0, port_rst}, 32'h0);
  endtask

  task automatic t_swc;
    do_write(32'h8, 32'h0004_0004);
    check("R4 enable", {31'b0, sw_ovr}, 32'h1);
    do_write(32'h8, 32'h0004_0000);
    check("R4 disable", {31'b0, sw_ovr}, 32'h0);
  endtask

  task automatic t_suspend;
    do_write(32'hC, 32'h003F_002A);
    check("R5 suspend", {26'b0, susp}, 32'h2A);
    do_write(32'hC, 32'h003F_0001);
    check("R5 run", {26'b0, susp}, 32'h01);
  endtask

  task automatic t_mask;
    do_write(32'hC, 32'h0000_FFFF);
    check("R2 no-enable susp", {26'b0, susp}, 32'h01);
    do_write(32'h0, 32'h00F0_5A5A);
    do_write(32'h8, 32'hFF00_A5FF);
    do_write(32'hC, 32'h0F0F_FFFF);
    check_outputs("R2");
    check_readback("R2");
    do_write(32'h0, 32'h1000_FFFF);
    check("R2 single-bit", {31'b0, port_rst}, 32'h1);
    check_readback("R2 single");
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    do_write(32'h4,         32'hFFFF_0000);
    do_write(32'h10,        32'hFFFF_FFFF);
    do_write(32'h1000_0000, 32'hFFFF_0000);
    check_outputs("R8");
    check_readback("R8");
    do_read(32'h4, v);         check("R7 0x04", v, 32'h0);
    do_read(32'h1000_0008, v); check("R7 aliased", v, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] old_v;
    old_v = {16'h0, mdl[1]};
    @(negedge clk);
    addr = 32'h8; wdata = 32'hFFFF_1234; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(32'h8, 32'hFFFF_1234);
    check("R10 old value", rdata, old_v);
    check_readback("R10 after");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) mdl[i] = '0;
    mdl[2] = 16'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_port_reset();
    t_swc();
    t_suspend();
    t_mask();
    t_unmapped();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule